// File: doc/BRIEF.md
# SPI Memory-Card Port on a Byte-Wide I/O Bus

This block lets a host on a simple 8-bit I/O bus talk to a memory card over SPI through a small window of I/O ports. Two neighbouring addresses both act as the data port, so the host can use byte or word I/O on it. Writing to the data port sends the written byte to the card. Reading from it clocks out an all-ones filler byte and returns the byte the card sent back. A third port holds the chip-select level, which software sets directly.

Every SPI exchange is one full byte in SPI mode 0: most significant bit first, MOSI changes only while SCLK is low, and MISO is sampled when SCLK rises. The SCLK rate is the system clock divided by a parameter. The ready output stays low for the whole exchange, so the host inserts wait states until the byte is done. Card command sets, CRC and block transfers are handled by software.

Top module: `spi_card_port`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 1 and io_ready is 1.
- R2: A write strobe to BASE_ADDR+0 or BASE_ADDR+1 sends io_wdata on spi_mosi most significant bit first, across exactly 8 rising edges of spi_sclk.
- R3: A read strobe to BASE_ADDR+0 or BASE_ADDR+1 sends 8'hFF on spi_mosi. After the exchange, io_rdata holds the 8 bits sampled on spi_miso at the rising spi_sclk edges, first bit in bit 7. Every data-port exchange, including a write, updates io_rdata this way.
- R4: A write to BASE_ADDR+2 sets spi_cs_n to io_wdata[0]. Bits 7:1 are ignored, and data-port exchanges leave spi_cs_n unchanged.
- R5: Decoding uses only io_addr[11:0], so bits 15:12 are ignored. Addresses outside the window start no exchange and change no state.
- R6: A write to BASE_ADDR+3, or a read from BASE_ADDR+2 or BASE_ADDR+3, keeps io_ready high, produces no spi_sclk edge, and leaves spi_cs_n and io_rdata unchanged.
- R7: io_ready goes low in the cycle after a data-port strobe and stays low for exactly 8*CLK_DIV clock cycles.
- R8: SPI mode 0 applies. spi_sclk is low whenever io_ready is high, spi_mosi is high when idle, and spi_mosi changes only in cycles where spi_sclk is low.
- R9: Any strobe that arrives while io_ready is low is ignored. It neither changes the byte being shifted nor spi_cs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Last byte received from the card |
| io_ready | output | 1 | Low while an exchange is in progress |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data to the card |
| spi_miso | input | 1 | SPI data from the card |
| spi_cs_n | output | 1 | Card chip select, active low |

## Verification
The write path is swept over all 256 data bytes, alternating between the two aliased data addresses. Each byte is paired with a different card reply, so a bit-order or aliasing fault shows up on both the MOSI and the MISO side. The read path is swept over all 256 card replies, which tells the filler byte apart from stale write data and catches any lost MISO bit. The remaining tests check the chip-select bit against its neighbouring bits, upper address bits that are set, the unused and out-of-window ports, and strobes issued during an exchange. Each of these tests separates a real side effect from a correctly ignored access.

// File: rtl/spi_card_pkg.sv
package spi_card_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_XWR   = 2'd1,
    ACC_XRD   = 2'd2,
    ACC_SELWR = 2'd3
  } acc_e;
endpackage

// File: rtl/spi_card_decode.sv
module spi_card_decode
  import spi_card_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'h280
) (
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output acc_e              kind,
  output logic [7:0]        tx_byte
);
  localparam logic [11:0] BASE12 = BASE_ADDR[11:0];

  logic [11:0] off;
  logic        wr_hit;
  logic        rd_hit;

  // offset within the window; only the low 12 address bits take part
  assign off    = io_addr[11:0] - BASE12;
  assign wr_hit = (off < 12'd4);
  assign rd_hit = (off < 12'd2);

  always_comb begin
    kind    = ACC_NONE;
    tx_byte = 8'hFF;
    if (io_wr && wr_hit) begin
      if (!off[1]) begin
        kind    = ACC_XWR;
        tx_byte = io_wdata;
      end else if (!off[0]) begin
        kind = ACC_SELWR;
      end
    end else if (io_rd && rd_hit) begin
      kind = ACC_XRD;
    end
  end
endmodule

// File: rtl/spi_card_tick.sv
module spi_card_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF == 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      assign tick = run && (cnt_q == LAST);

      always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_card_shifter.sv
module spi_card_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] load_byte,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic            busy_q, busy_d;
  logic            sclk_q, sclk_d;
  logic [BITS-1:0] tx_q, tx_d;
  logic [BITS-1:0] rx_q, rx_d;
  logic [BITS-1:0] out_q, out_d;
  logic [EW-1:0]   edge_q, edge_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    out_d  = out_q;
    edge_d = edge_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      tx_d   = load_byte;
      edge_d = '0;
    end else if (busy_q && tick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_q + 1'b1;
      if (!sclk_q) begin
        rx_d = {rx_q[BITS-2:0], miso};
      end else begin
        tx_d = {tx_q[BITS-2:0], 1'b1};
        if (edge_q == LAST_EDGE) begin
          busy_d = 1'b0;
          out_d  = rx_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '1;
      rx_q   <= '0;
      out_q  <= '0;
      edge_q <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      out_q  <= out_d;
      edge_q <= edge_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q ? tx_q[BITS-1] : 1'b1;
  assign rx_byte = out_q;
endmodule

// File: rtl/spi_card_port.sv
module spi_card_port
  import spi_card_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'h280,
  parameter int CLK_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  acc_e       kind;
  logic [7:0] tx_byte;
  logic       busy;
  logic       tick;
  logic       start;
  logic       cs_q, cs_d;

  spi_card_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .kind(kind), .tx_byte(tx_byte)
  );

  spi_card_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  assign start = !busy && ((kind == ACC_XWR) || (kind == ACC_XRD));

  spi_card_shifter #(.BITS(8)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(start), .load_byte(tx_byte),
    .tick(tick), .miso(spi_miso), .busy(busy), .sclk(spi_sclk),
    .mosi(spi_mosi), .rx_byte(io_rdata)
  );

  always_comb begin
    cs_d = cs_q;
    if (!busy && (kind == ACC_SELWR)) cs_d = io_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_d;
  end

  assign spi_cs_n = cs_q;
  assign io_ready = !busy;
endmodule

// File: rtl/spi_card_port_chk.sv
module spi_card_port_chk #(
  parameter int CLK_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_ready,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic [7:0] io_rdata
);
  logic        sclk_q;
  logic [3:0]  rise_cnt;
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
      low_cnt  <= '0;
    end else begin
      sclk_q <= spi_sclk;
      if (io_ready) begin
        rise_cnt <= '0;
        low_cnt  <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
        if (spi_sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |-> !spi_sclk); // R8
  AST_IDLE_MOSI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |-> spi_mosi); // R8
  AST_MOSI_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> !spi_sclk); // R8
  AST_EIGHT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_ready) |-> (rise_cnt == 4'd8)); // R2
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_ready) |-> (low_cnt == 16'(8 * CLK_DIV))); // R7
  AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_ready && $past(!io_ready)) |-> $stable(spi_cs_n)); // R9
  AST_RDATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_ready && $past(!io_ready)) |-> $stable(io_rdata)); // R3
endmodule

bind spi_card_port spi_card_port_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_ready(io_ready), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .io_rdata(io_rdata)
);

// File: tb/sim_spi_card_port.sv
`timescale 1ns/1ps
module sim_spi_card_port;
  localparam int CLK_DIV = 4;
  localparam int BUSY_N  = 8 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_ready;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso;

  int vectors = 0;
  int errors  = 0;

  logic [7:0] card_q = 8'h00;
  logic [7:0] mcap   = 8'h00;
  int         rises  = 0;

  always #2 clk = ~clk;

  spi_card_port #(.BASE_ADDR('h280), .CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_ready(io_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // card model: mode 0, presents next bit after each falling edge
  assign spi_miso = card_q[7];
  always @(negedge spi_sclk) card_q = {card_q[6:0], 1'b0};
  always @(posedge spi_sclk) begin
    mcap  = {mcap[6:0], spi_mosi};
    rises = rises + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle strobe, returns number of cycles io_ready stayed low
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        output int low_n);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    low_n = 0;
    while (!io_ready && low_n < 1000) begin
      low_n++;
      @(negedge clk);
    end
  endtask

  task automatic prep(input logic [7:0] card);
    card_q = card; mcap = 8'h00; rises = 0;
  endtask

  task automatic quiet_check(input string req, input logic cs_exp, input logic [7:0] rd_exp);
    repeat (3) @(negedge clk);
    chk(io_ready == 1'b1, req, io_ready, 1);
    chk(rises == 0, req, rises, 0);
    chk(spi_cs_n == cs_exp, req, spi_cs_n, cs_exp);
    chk(io_rdata == rd_exp, req, io_rdata, rd_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] last;
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    chk(spi_mosi == 1'b1, "R1 mosi", spi_mosi, 1);
    chk(io_ready == 1'b1, "R1 ready", io_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 chip select from bit 0 only
    access(1'b1, 16'h0282, 8'hFE, n);
    chk(spi_cs_n == 1'b0, "R4 cs low", spi_cs_n, 0);
    access(1'b1, 16'h0282, 8'h01, n);
    chk(spi_cs_n == 1'b1, "R4 cs high", spi_cs_n, 1);
    access(1'b1, 16'h0282, 8'h02, n);
    chk(spi_cs_n == 1'b0, "R4 cs bits ignored", spi_cs_n, 0);

    // R2 exhaustive write sweep over both aliases
    for (int b = 0; b < 256; b++) begin
      logic [7:0] reply;
      reply = 8'(b * 37 + 11);
      prep(reply);
      access(1'b1, (b[0] ? 16'h0281 : 16'h0280), 8'(b), n);
      chk(mcap == 8'(b), "R2 mosi byte", mcap, b);
      chk(rises == 8, "R2 edge count", rises, 8);
      chk(io_rdata == reply, "R3 rdata after write", io_rdata, reply);
      chk(n == BUSY_N, "R7 busy length", n, BUSY_N);
      chk(spi_cs_n == 1'b0, "R4 cs kept", spi_cs_n, 0);
    end

    // R3 exhaustive read sweep
    for (int b = 0; b < 256; b++) begin
      prep(8'(b));
      access(1'b0, (b[0] ? 16'h0280 : 16'h0281), 8'h00, n);
      chk(mcap == 8'hFF, "R3 filler", mcap, 8'hFF);
      chk(io_rdata == 8'(b), "R3 rdata", io_rdata, b);
      chk(n == BUSY_N, "R7 busy length rd", n, BUSY_N);
    end
    last = io_rdata;

    // R5 upper address bits ignored
    prep(8'h5A);
    access(1'b1, 16'hF281, 8'hC3, n);
    chk(mcap == 8'hC3, "R5 alias write", mcap, 8'hC3);
    chk(io_rdata == 8'h5A, "R5 alias rdata", io_rdata, 8'h5A);
    prep(8'h96);
    access(1'b0, 16'h7280, 8'h00, n);
    chk(io_rdata == 8'h96, "R5 alias read", io_rdata, 8'h96);
    access(1'b1, 16'hA282, 8'h01, n);
    chk(spi_cs_n == 1'b1, "R5 alias cs", spi_cs_n, 1);
    last = io_rdata;

    // R5 outside the window
    prep(8'h00);
    access(1'b1, 16'h0284, 8'h00, n);
    quiet_check("R5 outside wr", 1'b1, last);
    access(1'b1, 16'h027E, 8'h00, n);
    quiet_check("R5 below wr", 1'b1, last);
    access(1'b0, 16'h0380, 8'h00, n);
    quiet_check("R5 outside rd", 1'b1, last);

    // R6 unused ports
    access(1'b1, 16'h0283, 8'h00, n);
    quiet_check("R6 wr base+3", 1'b1, last);
    access(1'b0, 16'h0282, 8'h00, n);
    quiet_check("R6 rd base+2", 1'b1, last);
    access(1'b0, 16'h0283, 8'h00, n);
    quiet_check("R6 rd base+3", 1'b1, last);

    // R9 strobes during an exchange are dropped
    prep(8'h3C);
    @(negedge clk);
    io_addr = 16'h0280; io_wdata = 8'hA5; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    repeat (4) @(negedge clk);
    io_addr = 16'h0282; io_wdata = 8'h00; io_wr = 1'b1;
    @(negedge clk);
    io_addr = 16'h0281; io_wdata = 8'h0F;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b1; io_addr = 16'h0280;
    @(negedge clk);
    io_rd = 1'b0;
    while (!io_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(mcap == 8'hA5, "R9 byte kept", mcap, 8'hA5);
    chk(rises == 8, "R9 single exchange", rises, 8);
    chk(spi_cs_n == 1'b1, "R9 cs kept", spi_cs_n, 1);
    chk(io_rdata == 8'h3C, "R9 rdata", io_rdata, 8'h3C);
    chk(spi_sclk == 1'b0 && spi_mosi == 1'b1, "R8 idle levels", {spi_sclk, spi_mosi}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule